// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Command Master

This block drives a three-wire serial EEPROM on behalf of a host. The host presents an operation code, a 6-bit word address and, for writes, a 16-bit data word, and pulses `req`. The block raises chip select and clocks out a fixed 27-bit frame, most significant bit first. The frame holds a leading zero, an always-one start bit, a 2-bit opcode, the address, a 16-bit data field and a trailing zero. Every shift-clock level lasts a programmable number of system clocks.

For a read, the block captures the 16 bits the EEPROM returns during the data field. It then drops chip select and pulses `done` with the word on `rdata`. For a write or an erase, chip select is dropped briefly and raised again. The block then waits for the EEPROM to report ready on its data output, drops chip select and pulses `done`. Requests that arrive while a command is running are ignored.

Top module: `eewire_master`

## Requirements
- R1: While reset is held and in the first idle cycles after it, `ee_cs`, `ee_sck`, `ee_di`, `done` and `busy` are all 0.
- R2: When idle, a request with `op` = 01 (write), 10 (read) or 11 (erase) is accepted on the clock edge that samples `req`. In the next cycle `ee_cs` and `busy` go to 1. A request with `op` = 00 is ignored, and the outputs stay idle.
- R3: The frame is 27 bits, sent MSB first on `ee_di`. Bit 26 is 0 and bit 25 is the start bit 1. Bits 24..23 carry `op`, bits 22..17 carry `addr` (bit 22 = addr[5]) and bits 16..1 carry `wdata` (bit 16 = wdata[15]) for a write, or zeros for a read or erase. Bit 0 is 0.
- R4: Every phase lasts exactly DELAY system clocks. The first phase is chip-select setup with the clock low and bit 26 on `ee_di`. Then, for each frame bit, `ee_sck` is high for DELAY cycles, and between bits it is low for DELAY cycles.
- R5: `ee_di` changes only while `ee_sck` is low. Each new bit appears in the same cycle in which `ee_sck` falls.
- R6: For a read, `ee_do` is sampled on the system edge that raises `ee_sck` for frame bits 16 down to 1. The first sampled bit becomes rdata[15]. `ee_do` is ignored at every other edge. `rdata` is cleared when a request is accepted.
- R7: After the clock falls from bit 0, chip select stays high with the clock low for DELAY cycles. For a read, `ee_cs` then drops, and in that same cycle `done` is 1 with the captured word on `rdata`.
- R8: For a write or erase, chip select is low for DELAY cycles after that tail, then high again with the clock low. It stays high until `ee_do` is 1 at a clock edge. In the next cycle `ee_cs` is 0 and `done` is 1.
- R9: While `busy` is 1, `req` has no effect on the frame, the timing or the result.
- R10: `done` lasts one cycle. `busy` is 0 in the `done` cycle and while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Command request, sampled while idle |
| op | input | 2 | 01 write, 10 read, 11 erase, 00 no operation |
| addr | input | 6 | EEPROM word address |
| wdata | input | 16 | Write data |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Word captured by the last read |
| ee_cs | output | 1 | EEPROM chip select, active high |
| ee_sck | output | 1 | EEPROM shift clock, idles low |
| ee_di | output | 1 | Serial data toward the EEPROM |
| ee_do | input | 1 | Serial data from the EEPROM |

## Verification
The hardest case to reach is the read sample point. `ee_do` only matters at the single system edge that raises the shift clock for frame bits 16 to 1. During a read, the bench therefore holds the data bit on `ee_do` only through the low phase before each such edge and drives 1 at every other moment. A sample taken one edge early or late, or outside the window, then corrupts `rdata`. The ready wait is stressed the same way: `ee_do` is already 1 during the gap before polling starts, and the EEPROM is made ready both at once and after a delay.

// File: rtl/eewire_pkg.sv
package eewire_pkg;
  parameter int unsigned EE_ADDR_W = 6;
  parameter int unsigned EE_DATA_W = 16;
  localparam int unsigned EE_CMD_W   = 3 + EE_ADDR_W;
  localparam int unsigned EE_FRAME_W = 1 + EE_CMD_W + EE_DATA_W + 1;
  localparam int unsigned EE_IDX_W   = $clog2(EE_FRAME_W);

  localparam logic [EE_IDX_W-1:0] EE_RX_LO = EE_IDX_W'(1);
  localparam logic [EE_IDX_W-1:0] EE_RX_HI = EE_IDX_W'(EE_DATA_W);

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_ERASE = 2'b11
  } ee_op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CSUP, ST_HIGH, ST_LOW, ST_TAIL, ST_GAP, ST_POLL
  } ee_state_e;

  // Pad bit, start bit, opcode, address, payload, pad bit.
  function automatic logic [EE_FRAME_W-1:0] ee_build_frame(
    input ee_op_e                 o,
    input logic [EE_ADDR_W-1:0]   a,
    input logic [EE_DATA_W-1:0]   d
  );
    logic [EE_DATA_W-1:0] payload;
    payload = (o == OP_WRITE) ? d : '0;
    return {1'b0, 1'b1, o, a, payload, 1'b0};
  endfunction

  // True when the frame bit being clocked lies in the returned-data field.
  function automatic logic ee_in_rx_window(input logic [EE_IDX_W-1:0] idx);
    return (idx >= EE_RX_LO) && (idx <= EE_RX_HI);
  endfunction
endpackage

// File: rtl/ee_pacer.sv
module ee_pacer #(
  parameter int unsigned DELAY = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic expire
);
  localparam int unsigned CW = $clog2(DELAY + 1);
  localparam logic [CW-1:0] RELOAD = CW'(DELAY - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (restart)        cnt_q <= RELOAD;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expire = (cnt_q == '0);
endmodule

// File: rtl/ee_frame_shifter.sv
module ee_frame_shifter
  import eewire_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [EE_FRAME_W-1:0] frame_in,
  input  logic                  shift,
  output logic                  bit_out,
  output logic [EE_IDX_W-1:0]   bit_idx,
  output logic                  last_bit
);
  localparam logic [EE_IDX_W-1:0] TOP_IDX = EE_IDX_W'(EE_FRAME_W - 1);

  logic [EE_FRAME_W-1:0] frame_q;
  logic [EE_IDX_W-1:0]   idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_q <= '0;
      idx_q   <= '0;
    end else if (load) begin
      frame_q <= frame_in;
      idx_q   <= TOP_IDX;
    end else if (shift) begin
      frame_q <= {frame_q[EE_FRAME_W-2:0], 1'b0};
      if (idx_q != '0) idx_q <= idx_q - 1'b1;
    end
  end

  assign bit_out  = frame_q[EE_FRAME_W-1];
  assign bit_idx  = idx_q;
  assign last_bit = (idx_q == '0);
endmodule

// File: rtl/ee_rx_capture.sv
module ee_rx_capture
  import eewire_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 sample,
  input  logic                 din,
  output logic [EE_DATA_W-1:0] word
);
  logic [EE_DATA_W-1:0] word_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       word_q <= '0;
    else if (clear)   word_q <= '0;
    else if (sample)  word_q <= {word_q[EE_DATA_W-2:0], din};
  end

  assign word = word_q;
endmodule

// File: rtl/eewire_master.sv
module eewire_master
  import eewire_pkg::*;
#(
  parameter int unsigned DELAY = 40
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req,
  input  logic [1:0]           op,
  input  logic [EE_ADDR_W-1:0] addr,
  input  logic [EE_DATA_W-1:0] wdata,
  output logic                 busy,
  output logic                 done,
  output logic [EE_DATA_W-1:0] rdata,
  output logic                 ee_cs,
  output logic                 ee_sck,
  output logic                 ee_di,
  input  logic                 ee_do
);
  ee_state_e state_q, state_d;
  ee_op_e    op_q;
  logic      cs_q, cs_d, sck_q, sck_d, done_q, done_d;

  // Named events, also observed by the checker.
  logic accept_ev;
  logic sample_ev;
  logic rise_ev;
  logic shift_ev;
  logic pace_restart;
  logic pace_expire;

  logic                 frame_bit;
  logic [EE_IDX_W-1:0]  bit_idx;
  logic                 last_bit;

  assign accept_ev = (state_q == ST_IDLE) && req && (op != OP_NONE);
  assign sample_ev = rise_ev && (op_q == OP_READ) && ee_in_rx_window(bit_idx);

  ee_pacer #(.DELAY(DELAY)) u_pacer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (pace_restart),
    .expire  (pace_expire)
  );

  ee_frame_shifter u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept_ev),
    .frame_in (ee_build_frame(ee_op_e'(op), addr, wdata)),
    .shift    (shift_ev),
    .bit_out  (frame_bit),
    .bit_idx  (bit_idx),
    .last_bit (last_bit)
  );

  ee_rx_capture u_rx (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (accept_ev),
    .sample (sample_ev),
    .din    (ee_do),
    .word   (rdata)
  );

  always_comb begin
    state_d      = state_q;
    cs_d         = cs_q;
    sck_d        = sck_q;
    done_d       = 1'b0;
    pace_restart = 1'b0;
    rise_ev      = 1'b0;
    shift_ev     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept_ev) begin
          state_d      = ST_CSUP;
          cs_d         = 1'b1;
          sck_d        = 1'b0;
          pace_restart = 1'b1;
        end
      end
      ST_CSUP, ST_LOW: begin
        if (pace_expire) begin
          state_d      = ST_HIGH;
          sck_d        = 1'b1;
          pace_restart = 1'b1;
          rise_ev      = 1'b1;
        end
      end
      ST_HIGH: begin
        if (pace_expire) begin
          state_d      = last_bit ? ST_TAIL : ST_LOW;
          sck_d        = 1'b0;
          pace_restart = 1'b1;
          shift_ev     = 1'b1;
        end
      end
      ST_TAIL: begin
        if (pace_expire) begin
          cs_d         = 1'b0;
          pace_restart = 1'b1;
          if (op_q == OP_READ) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else begin
            state_d = ST_GAP;
          end
        end
      end
      ST_GAP: begin
        if (pace_expire) begin
          state_d = ST_POLL;
          cs_d    = 1'b1;
        end
      end
      ST_POLL: begin
        if (ee_do) begin
          state_d = ST_IDLE;
          cs_d    = 1'b0;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= OP_NONE;
      cs_q    <= 1'b0;
      sck_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cs_q    <= cs_d;
      sck_q   <= sck_d;
      done_q  <= done_d;
      if (accept_ev) op_q <= ee_op_e'(op);
    end
  end

  assign busy   = (state_q != ST_IDLE);
  assign done   = done_q;
  assign ee_cs  = cs_q;
  assign ee_sck = sck_q;
  assign ee_di  = frame_bit;
endmodule

// File: rtl/eewire_master_chk.sv
module eewire_master_chk #(
  parameter int unsigned DELAY = 40
) (
  input logic clk,
  input logic rst_n,
  input logic req,
  input logic busy,
  input logic done,
  input logic ee_cs,
  input logic ee_sck,
  input logic ee_di,
  input logic accept_ev,
  input logic sample_ev
);
  localparam int unsigned HW = $clog2(DELAY + 2);
  localparam logic [HW-1:0] HMAX = HW'(DELAY);

  logic          prev_sck_q;
  logic [HW-1:0] hold_q;

  // Counts how many cycles the shift clock has kept its present level.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_sck_q <= 1'b0;
      hold_q     <= '0;
    end else begin
      prev_sck_q <= ee_sck;
      if (ee_sck != prev_sck_q) hold_q <= HW'(1);
      else if (hold_q < HMAX)   hold_q <= hold_q + 1'b1;
    end
  end

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r5_di_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_sck && $past(ee_sck)) |-> $stable(ee_di));

  a_r4_pace_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_sck != prev_sck_q) |-> (hold_q >= HMAX));

  a_r7_cs_drop_clk_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ee_cs) |-> !ee_sck);

  a_r2_accept_raises_cs: assert property (@(posedge clk) disable iff (!rst_n)
    accept_ev |=> (ee_cs && busy));

  a_r9_busy_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req));

  a_r9_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    accept_ev |-> !busy);

  a_r6_sample_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    sample_ev |=> $rose(ee_sck));
endmodule

bind eewire_master eewire_master_chk #(.DELAY(DELAY)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req       (req),
  .busy      (busy),
  .done      (done),
  .ee_cs     (ee_cs),
  .ee_sck    (ee_sck),
  .ee_di     (ee_di),
  .accept_ev (accept_ev),
  .sample_ev (sample_ev)
);

// File: tb/eewire_master_bench.sv
module eewire_master_bench;
  localparam int D = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [5:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic        busy, done, ee_cs, ee_sck, ee_di;
  logic        ee_do = 1'b0;
  logic [15:0] rdata;

  always #2 clk = ~clk;  // 250 MHz

  eewire_master #(.DELAY(D)) u_eewire_master (
    .clk(clk), .rst_n(rst_n), .req(req), .op(op), .addr(addr), .wdata(wdata),
    .busy(busy), .done(done), .rdata(rdata),
    .ee_cs(ee_cs), .ee_sck(ee_sck), .ee_di(ee_di), .ee_do(ee_do)
  );

  // Expected cycle tuples {cs, sck, di, done, busy, drive_do}.
  logic [5:0]  exp_q[$];
  int          tag_q[$];
  int          idle_tag = 1;
  int          force_tag = 0;
  logic [15:0] exp_rd = '0;
  int          n_checks = 0;
  int          n_err = 0;
  int          cyc = 0;
  bit          finished = 0;

  function automatic logic fbit(input logic [1:0] o, input logic [5:0] a,
                                input logic [15:0] d, input int i);
    if (i == 25) return 1'b1;
    if (i == 24) return o[1];
    if (i == 23) return o[0];
    if (i >= 17 && i <= 22) return a[i-17];
    if (i >= 1 && i <= 16) return (o == 2'b01) ? d[i-1] : 1'b0;
    return 1'b0;
  endfunction

  task automatic put(input int n, input logic [5:0] v, input int tg);
    for (int k = 0; k < n; k++) begin
      exp_q.push_back(v);
      tag_q.push_back(force_tag != 0 ? force_tag : tg);
    end
  endtask

  // Behavioural model of one command: the whole expected waveform.
  task automatic plan(input logic [1:0] o, input logic [5:0] a, input logic [15:0] d,
                      input logic [15:0] rd, input int busy_cyc);
    bit rd_op;
    rd_op = (o == 2'b10);
    put(D, {1'b1, 1'b0, fbit(o, a, d, 26), 1'b0, 1'b1, 1'b1}, 4);          // R4 setup
    for (int i = 26; i >= 0; i--) begin
      put(D, {1'b1, 1'b1, fbit(o, a, d, i), 1'b0, 1'b1, 1'b1}, 5);         // R5 high
      if (i > 0) begin
        int j = i - 1;
        logic drv;
        drv = (rd_op && j >= 1 && j <= 16) ? rd[j-1] : 1'b1;
        put(D, {1'b1, 1'b0, fbit(o, a, d, j), 1'b0, 1'b1, drv},
            (rd_op && j >= 1 && j <= 16) ? 6 : 3);                        // R6 / R3
      end
    end
    put(D, {1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1}, 7);                       // R7 tail
    if (rd_op) begin
      exp_rd = rd;
      put(1, {1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1}, 7);
    end else begin
      exp_rd = 16'h0000;
      put(D, {1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1}, 8);                     // R8 gap
      put(busy_cyc, {1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, 8);
      put(1, {1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1}, 8);
      put(1, {1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1}, 8);
    end
  endtask

  task automatic cycle();
    logic [5:0] ev;
    logic [4:0] got;
    int tg;
    @(negedge clk);
    cyc++;
    if (exp_q.size() != 0) begin
      ev = exp_q.pop_front();
      tg = tag_q.pop_front();
    end else begin
      ev = 6'b000001;
      tg = idle_tag;
    end
    got = {ee_cs, ee_sck, ee_di, done, busy};
    n_checks++;
    if (got !== ev[5:1]) begin
      n_err++;
      $display("FAIL R%0d: cycle %0d {cs,sck,di,done,busy} actual %b expected %b",
               tg, cyc, got, ev[5:1]);
    end
    if (ev[2]) begin  // done cycle: R6 / R7 result word
      n_checks++;
      if (rdata !== exp_rd) begin
        n_err++;
        $display("FAIL R6: cycle %0d rdata actual %h expected %h", cyc, rdata, exp_rd);
      end
    end
    ee_do = ev[0];
    req = 1'b0;
  endtask

  task automatic launch(input logic [1:0] o, input logic [5:0] a, input logic [15:0] d,
                        input logic [15:0] rd, input int busy_cyc, input bit expect_run);
    cycle();
    req = 1'b1; op = o; addr = a; wdata = d;
    if (expect_run) plan(o, a, d, rd, busy_cyc);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) cycle();
    repeat (4) cycle();
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  endtask

  initial begin
    // R1: reset state and first idle cycles
    idle_tag = 1;
    repeat (4) cycle();
    rst_n = 1'b1;
    repeat (3) cycle();

    // R3 R4 R5 R8: write with delayed ready
    idle_tag = 10;
    launch(2'b01, 6'h2A, 16'hA5C3, 16'h0, 5, 1);
    drain();

    // R6 R7: read with a mixed word
    launch(2'b10, 6'h15, 16'hFFFF, 16'h9E61, 0, 1);
    drain();

    // R8: erase, EEPROM ready at once
    launch(2'b11, 6'h3F, 16'h1234, 16'h0, 0, 1);
    drain();

    // R6: read boundary words
    launch(2'b10, 6'h00, 16'h0, 16'h0001, 0, 1);
    drain();
    launch(2'b10, 6'h01, 16'h0, 16'h8000, 0, 1);
    drain();

    // R2: no-operation request is ignored
    idle_tag = 2;
    launch(2'b00, 6'h11, 16'hBEEF, 16'h0, 0, 0);
    repeat (12) cycle();

    // R9: requests during a read and during a write poll are ignored
    idle_tag = 10;
    force_tag = 9;
    launch(2'b10, 6'h2C, 16'h0, 16'h5A3C, 0, 1);
    repeat (5) cycle();
    while (exp_q.size() >= 2) begin
      cycle();
      if (exp_q.size() >= 2 && (cyc % 7) == 0) begin
        req = 1'b1; op = 2'b01; addr = 6'h3F; wdata = 16'hFFFF;
      end
    end
    drain();
    launch(2'b01, 6'h07, 16'h0F0F, 16'h0, 9, 1);
    repeat (4) cycle();
    while (exp_q.size() >= 2) begin
      cycle();
      if (exp_q.size() >= 2 && (cyc % 5) == 0) begin
        req = 1'b1; op = 2'b11; addr = 6'h00; wdata = 16'h0000;
      end
    end
    drain();
    force_tag = 0;

    finished = 1;
    report();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_err++;
      n_checks++;
      $display("FAIL watchdog: run did not complete, actual hung expected finished");
      report();
    end
  end
endmodule